// File: doc/BRIEF.md
# Exception Escalation and Vector Unit

This block runs when an exception is raised. It reads the cause code and the operating mode that was active at the time. From these it picks the mode that will handle the exception and forms the address of that mode's handler entry. Each mode has its own table of handler entries. A 64-bit escalation bitmap holds one bit for each pairing of mode and cause. When the bit for the current pairing is set, the exception moves up one privilege level. The bit for the new level and the same cause is then tested, so escalation can chain upward. The highest mode never escalates.

Modes are numbered from 0 (application) to 3 (most privileged). The bitmap and the four table bases sit in registers inside the block. Software updates them through a simple write port. The result appears on registered outputs one cycle after the raise strobe, together with a one-cycle take pulse.

Top module: `exc_escalate_vec`

## Requirements
- R1: While reset is asserted, and after reset until the first raise, take_o, tgt_mode_o and vec_addr_o are all zero. The bitmap and all four bases clear to zero.
- R2: take_o is high in exactly the cycle after a cycle with raise_i high, and low in every other cycle.
- R3: If the bitmap bit at index mode*16+cause is clear for the raised cause and current mode, the target mode equals the current mode.
- R4: If that bit is set, the exception moves up one mode. The bit for the new mode and the same cause is tested in the same way, so an exception can chain up to mode 3.
- R5: Mode 3 never escalates: its bits (indices 48 to 63) have no effect on the result.
- R6: vec_addr_o equals the base of the target mode plus cause times 8.
- R7: A write with wr_sel_i=0 loads the bitmap. A write with wr_sel_i=1..4 loads the base of mode wr_sel_i-1. A write with wr_sel_i=5..7 changes nothing.
- R8: A write in the same cycle as a raise does not affect that raise. It takes effect from the next raise on.
- R9: Between raises, tgt_mode_o and vec_addr_o hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_i | input | 1 | Exception raise strobe |
| cause_i | input | 4 | Exception cause code |
| mode_i | input | 2 | Operating mode when the exception occurs |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Write target: 0 bitmap, 1..4 base of mode 0..3 |
| wr_data_i | input | 64 | Write data |
| take_o | output | 1 | One-cycle pulse: a result is valid |
| tgt_mode_o | output | 2 | Mode chosen to handle the exception |
| vec_addr_o | output | 64 | Handler entry address |

## Verification
The assertions check on every cycle that take_o follows the raise strobe by one cycle, and that the target mode is never below the raising mode. They also check that a raise from mode 3 stays at mode 3 and that both result outputs hold steady between raises. Only the bench's scenarios can show the exact chaining decisions, since those depend on the programmed bitmap. The same is true of the address sums, the write decode including the ignored selects, and the rule that a write in the same cycle as a raise is deferred.

// File: rtl/exc_escalate_vec.sv
module exc_escalate_vec #(
  parameter int MODES       = 4,
  parameter int CAUSES      = 16,
  parameter int ADDR_W      = 64,
  parameter int ENTRY_BYTES = 8,
  localparam int MW    = $clog2(MODES),
  localparam int CW    = $clog2(CAUSES),
  localparam int EW    = MODES * CAUSES,
  localparam int SEL_W = $clog2(MODES + 1),
  localparam int SHIFT = $clog2(ENTRY_BYTES),
  localparam int DW    = (EW > ADDR_W) ? EW : ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_i,
  input  logic [CW-1:0]     cause_i,
  input  logic [MW-1:0]     mode_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic              take_o,
  output logic [MW-1:0]     tgt_mode_o,
  output logic [ADDR_W-1:0] vec_addr_o
);

  localparam logic [MW-1:0] TOP_MODE = MW'(MODES - 1);

  logic [EW-1:0]     esc_q;
  logic [ADDR_W-1:0] base_q [MODES];
  logic [MW-1:0]     tgt;
  logic [ADDR_W-1:0] vec;

  // MODES and CAUSES are powers of two, so {mode,cause} is the bit index
  always_comb begin
    tgt = mode_i;
    for (int k = 0; k < MODES - 1; k++)
      if (tgt != TOP_MODE && esc_q[{tgt, cause_i}])
        tgt = tgt + MW'(1);
  end

  assign vec = base_q[tgt] + (ADDR_W'(cause_i) << SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esc_q <= '0;
      for (int m = 0; m < MODES; m++) base_q[m] <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == '0) esc_q <= wr_data_i[EW-1:0];
      for (int m = 0; m < MODES; m++)
        if (wr_sel_i == SEL_W'(m + 1)) base_q[m] <= wr_data_i[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      tgt_mode_o <= '0;
      vec_addr_o <= '0;
    end else begin
      take_o <= raise_i;
      if (raise_i) begin
        tgt_mode_o <= tgt;
        vec_addr_o <= vec;
      end
    end
  end

endmodule

module exc_escalate_vec_chk #(
  parameter int MODES  = 4,
  parameter int ADDR_W = 64,
  localparam int MW    = $clog2(MODES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              raise_i,
  input logic [MW-1:0]     mode_i,
  input logic              take_o,
  input logic [MW-1:0]     tgt_mode_o,
  input logic [ADDR_W-1:0] vec_addr_o
);

  // R2
  take_after_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> take_o);

  // R2
  no_spurious_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_i |=> !take_o);

  // R3
  never_below_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> tgt_mode_o >= $past(mode_i));

  // R5
  top_mode_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && mode_i == MW'(MODES - 1)) |=> tgt_mode_o == MW'(MODES - 1));

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_i |=> ($stable(tgt_mode_o) && $stable(vec_addr_o)));

endmodule

bind exc_escalate_vec exc_escalate_vec_chk #(.MODES(MODES), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/exc_escalate_vec_tb.sv
module exc_escalate_vec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise_i = 1'b0;
  logic [3:0]  cause_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        take_o;
  logic [1:0]  tgt_mode_o;
  logic [63:0] vec_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_escalate_vec dut_i (.*);

  // {mode, cause, expected mode, expected address}
  localparam logic [71:0] VECS [8] = '{
    {2'd0, 4'd0,  2'd0, 64'h0000_0000_0000_1000},
    {2'd0, 4'd5,  2'd2, 64'h0000_3000_0000_0028},
    {2'd1, 4'd5,  2'd2, 64'h0000_3000_0000_0028},
    {2'd0, 4'd2,  2'd1, 64'h0000_0000_0000_2010},
    {2'd3, 4'd7,  2'd3, 64'h0000_0000_FFFF_0038},
    {2'd2, 4'd15, 2'd3, 64'h0000_0000_FFFF_0078},
    {2'd2, 4'd5,  2'd2, 64'h0000_3000_0000_0028},
    {2'd1, 4'd2,  2'd1, 64'h0000_0000_0000_2010}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [63:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic raise(input logic [1:0] m, input logic [3:0] c);
    @(negedge clk);
    raise_i = 1'b1; mode_i = m; cause_i = c;
    @(negedge clk);
    raise_i = 1'b0;
  endtask

  task automatic expect_result(input string req, input logic [1:0] em, input logic [63:0] ea);
    check({req, " take"}, 64'(take_o), 64'd1);
    check({req, " mode"}, 64'(tgt_mode_o), 64'(em));
    check({req, " addr"}, vec_addr_o, ea);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: in reset
    check("R1 take", 64'(take_o), 64'd0);
    check("R1 mode", 64'(tgt_mode_o), 64'd0);
    check("R1 addr", vec_addr_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'(take_o), 64'd0);
    // R1: cleared bitmap and bases -> mode unchanged, address = cause*8
    raise(2'd1, 4'd3);
    expect_result("R1 cleared regs", 2'd1, 64'h18);

    // R7: program bases and bitmap
    write_reg(3'd1, 64'h0000_0000_0000_1000);
    write_reg(3'd2, 64'h0000_0000_0000_2000);
    write_reg(3'd3, 64'h0000_3000_0000_0000);
    write_reg(3'd4, 64'h0000_0000_FFFF_0000);
    write_reg(3'd0, (64'd1 << 5) | (64'd1 << 21) | (64'd1 << 2) | (64'd1 << 55) | (64'd1 << 47));

    // R3 R4 R5 R6: table
    for (int i = 0; i < 8; i++) begin
      raise(VECS[i][71:70], VECS[i][69:66]);
      expect_result("R3/R4/R5/R6 table", VECS[i][65:64], VECS[i][63:0]);
    end

    // R2 and R9: pulse ends, outputs hold
    @(negedge clk);
    check("R2 take low", 64'(take_o), 64'd0);
    check("R9 mode hold", 64'(tgt_mode_o), 64'd1);
    check("R9 addr hold", vec_addr_o, 64'h2010);

    // R7: selects 5..7 ignored
    write_reg(3'd5, 64'hDEAD_BEEF_DEAD_BEEF);
    write_reg(3'd6, 64'hDEAD_BEEF_DEAD_BEEF);
    write_reg(3'd7, 64'hDEAD_BEEF_DEAD_BEEF);
    raise(2'd0, 4'd0);
    expect_result("R7 ignored select base0", 2'd0, 64'h1000);
    raise(2'd0, 4'd5);
    expect_result("R7 ignored select bitmap", 2'd2, 64'h0000_3000_0000_0028);

    // R4: full chain to mode 3
    write_reg(3'd0, (64'd1 << 9) | (64'd1 << 25) | (64'd1 << 41) | (64'd1 << 57));
    raise(2'd0, 4'd9);
    expect_result("R4 chain to top", 2'd3, 64'h0000_0000_FFFF_0048);
    // R5: bit 57 (mode 3, cause 9) has no effect
    raise(2'd3, 4'd9);
    expect_result("R5 top no escalate", 2'd3, 64'h0000_0000_FFFF_0048);

    // R8: same-cycle write is deferred
    @(negedge clk);
    raise_i = 1'b1; mode_i = 2'd0; cause_i = 4'd0;
    wr_en_i = 1'b1; wr_sel_i = 3'd1; wr_data_i = 64'h5000;
    @(negedge clk);
    raise_i = 1'b0; wr_en_i = 1'b0;
    expect_result("R8 same cycle old base", 2'd0, 64'h1000);
    raise(2'd0, 4'd0);
    expect_result("R8 next raise new base", 2'd0, 64'h5000);

    // R2: back-to-back raises
    @(negedge clk);
    raise_i = 1'b1; mode_i = 2'd1; cause_i = 4'd1;
    @(negedge clk);
    expect_result("R2 back-to-back first", 2'd1, 64'h2008);
    mode_i = 2'd2; cause_i = 4'd2;
    @(negedge clk);
    raise_i = 1'b0;
    expect_result("R2 back-to-back second", 2'd2, 64'h0000_3000_0000_0010);
    @(negedge clk);
    check("R2 take drops", 64'(take_o), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule